// File: doc/BRIEF.md
# Golden Parity Monitor

This block watches the running state of a design under debug without stopping it. Several signature registers compact that state continuously. The monitor folds each signature into a single bit, using an XOR over a selectable subset of that signature's bits. It then XORs those bits into one composite parity bit, so that one bit stands for the whole compacted state in every cycle.

A slow external checker supplies expected ("golden") parity bits through a valid/acknowledge pair. The internal clock runs faster than that checker. For this reason the composite bit is compared only once per programmable period, set to the ratio of the two clock rates. For example, a 3 GHz core checked at 100 MHz uses a period of 30.

The first mismatch raises a sticky halt request and captures the cycle index at which it occurred. Debug can then stop long before the error shows up at the functional outputs. A compare strobe that finds no golden bit available raises a sticky underrun flag and performs no compare.

Top module: `gold_parity_monitor`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `halt` and `underrun` are 0 and `mismatch_cycle` is 0.
- R2: The parity of signature i is the XOR of the bits of `sig_bus[i*SIG_W +: SIG_W]` whose matching bit in `sig_mask` is 1. Bits with mask 0 have no effect on `comp_parity`.
- R3: `comp_parity` is the XOR of all per-signature parities and follows `sig_bus`/`sig_mask` in the same cycle (no register on the path).
- R4: Cycle index n counts clock cycles from 0, starting with the first cycle after reset is released. With a steady `period` value P ≥ 1, `check_strobe` is 1 exactly in the cycles where n mod P = P-1.
- R5: `gold_ack` is 1 exactly in the cycles where `check_strobe` is 1, `gold_valid` is 1 and `halt` is 0. A golden bit is consumed only in those cycles.
- R6: If a consumed golden bit differs from `comp_parity`, `halt` is 1 from the next cycle onward and stays 1 until reset.
- R7: On that first mismatch, `mismatch_cycle` captures the cycle index n of the failing strobe. Later mismatches do not change it.
- R8: A strobe cycle with `gold_valid` at 0 sets the sticky `underrun` flag from the next cycle. No compare takes place, so `halt` stays 0 whatever `gold_bit` holds.
- R9: A `period` of 0 behaves like 1: `check_strobe` is 1 in every cycle.
- R10: If `period` is lowered to a value at or below the number of cycles elapsed since the last strobe, `check_strobe` is 1 in that same cycle. The count then restarts, so the next strobe follows P cycles later.
- R11: Flipping an even number of selected bits inside one signature leaves `comp_parity` unchanged (the known blind spot of a single parity check).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sig_bus | input | NUM_SIG*SIG_W | All signature registers, signature i at bits i*SIG_W upward |
| sig_mask | input | NUM_SIG*SIG_W | Per-bit select for the parity subset (1 = included) |
| period | input | PER_W | Compare period in internal cycles (0 treated as 1) |
| gold_bit | input | 1 | Expected composite parity from the external checker |
| gold_valid | input | 1 | `gold_bit` is available |
| gold_ack | output | 1 | Golden bit consumed in this cycle |
| check_strobe | output | 1 | This cycle is a compare point |
| comp_parity | output | 1 | Composite parity of the current state |
| halt | output | 1 | Sticky halt request after first mismatch |
| underrun | output | 1 | Sticky flag: a strobe found no golden bit |
| mismatch_cycle | output | CYC_W | Cycle index of the first mismatching compare |

## Verification
Two situations are hard to reach from the ports. The first is a period lowered in the middle of a count, below the phase already reached. The bench runs seven cycles with a period of ten, writes three, and expects a strobe in that same cycle and another three cycles later. The second is the behaviour after a halt. The bench forces a second mismatch on a later strobe and checks that no acknowledge appears and that the captured index keeps the first failing cycle. Underrun is reached by withdrawing `gold_valid` for exactly one strobe while presenting a wrong `gold_bit`. The bench then checks that only the underrun flag reacts.

// File: rtl/gpm_pkg.sv
// Shared types for the golden parity monitor.
// Assumes nothing beyond standard SystemVerilog packed structs.
package gpm_pkg;

    // Sticky error state held by the verdict stage
    typedef struct packed {
        logic halt;
        logic underrun;
    } gpm_flags_t;

endpackage

// File: rtl/gpm_sig_reduce.sv
// Folds NUM_SIG signatures into one composite parity bit.
// Each signature contributes the XOR of its mask-selected bits.
// Assumes sig_mask is quasi-static configuration; the path is purely combinational.
module gpm_sig_reduce #(
    parameter int unsigned NUM_SIG = 4,
    parameter int unsigned SIG_W   = 16
) (
    input  logic [NUM_SIG*SIG_W-1:0] sig_bus,
    input  logic [NUM_SIG*SIG_W-1:0] sig_mask,
    output logic                     comp_parity
);

    logic [NUM_SIG-1:0] sig_par;

    // One masked XOR tree per signature
    for (genvar gi = 0; gi < NUM_SIG; gi++) begin : g_sig
        logic [SIG_W-1:0] picked;
        assign picked      = sig_bus[gi*SIG_W +: SIG_W] & sig_mask[gi*SIG_W +: SIG_W];
        assign sig_par[gi] = ^picked;
    end

    // Composite bit over all signatures
    assign comp_parity = ^sig_par;

endmodule

// File: rtl/gpm_period_timer.sv
// Free-running cycle index plus a phase counter that produces the compare strobe.
// Strobe fires when the phase has reached period-1 (period 0 acts as 1),
// then the phase wraps to zero. A shortened period takes effect at once.
// Assumes synchronous active-low reset.
module gpm_period_timer #(
    parameter int unsigned PER_W = 16,
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] period,
    output logic             strobe,
    output logic [CYC_W-1:0] cyc
);

    logic [PER_W-1:0] phase;
    logic [PER_W-1:0] last_phase;

    // Terminal phase value for the current period setting
    always_comb begin
        last_phase = (period == '0) ? '0 : period - 1'b1;
    end

    assign strobe = (phase >= last_phase);

    // Phase advances each cycle and restarts after a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (strobe) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Cycle index since reset release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    // R4: every strobe restarts the phase count
    p_wrap_after_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (phase == '0));

    // R4: the cycle index advances by exactly one per clock
    p_cyc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cyc == $past(cyc) + 1'b1));

endmodule

// File: rtl/gpm_verdict.sv
// Compares the composite parity with the golden bit on each strobe.
// First mismatch sets a sticky halt and captures the cycle index; after that
// no golden bit is consumed. A strobe without a valid golden bit sets a
// sticky underrun flag instead of comparing. Assumes synchronous active-low reset.
module gpm_verdict
    import gpm_pkg::*;
#(
    parameter int unsigned CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             comp_parity,
    input  logic             gold_bit,
    input  logic             gold_valid,
    input  logic [CYC_W-1:0] cyc,
    output logic             gold_ack,
    output gpm_flags_t       flags,
    output logic [CYC_W-1:0] mismatch_cycle
);

    logic compare_now;
    logic miss_now;

    // Compare happens only on a strobe with data available, before any halt
    always_comb begin
        compare_now = strobe && gold_valid && !flags.halt;
        miss_now    = compare_now && (gold_bit != comp_parity);
    end

    assign gold_ack = compare_now;

    // Sticky halt and first-failure capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.halt     <= 1'b0;
            mismatch_cycle <= '0;
        end else if (miss_now) begin
            flags.halt     <= 1'b1;
            mismatch_cycle <= cyc;
        end
    end

    // Sticky underrun when a strobe finds no golden bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags.underrun <= 1'b0;
        end else if (strobe && !gold_valid && !flags.halt) begin
            flags.underrun <= 1'b1;
        end
    end

    // R6: halt never drops without reset
    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flags.halt |=> flags.halt);

    // R6: halt rises only after a consumed golden bit
    p_halt_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.halt) |-> $past(strobe && gold_valid));

    // R7: captured index frozen once halted
    p_capture_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags.halt |=> $stable(mismatch_cycle));

    // R8: underrun rises only after a strobe without golden data
    p_underrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags.underrun) |-> $past(strobe && !gold_valid));

endmodule

// File: rtl/gold_parity_monitor.sv
// Top of the golden parity monitor: parity reduction, period timer, verdict.
// Assumes the golden source holds gold_bit/gold_valid until gold_ack and that
// all inputs are synchronous to clk.
module gold_parity_monitor
    import gpm_pkg::*;
#(
    parameter int unsigned NUM_SIG = 4,
    parameter int unsigned SIG_W   = 16,
    parameter int unsigned PER_W   = 16,
    parameter int unsigned CYC_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SIG*SIG_W-1:0] sig_bus,
    input  logic [NUM_SIG*SIG_W-1:0] sig_mask,
    input  logic [PER_W-1:0]         period,
    input  logic                     gold_bit,
    input  logic                     gold_valid,
    output logic                     gold_ack,
    output logic                     check_strobe,
    output logic                     comp_parity,
    output logic                     halt,
    output logic                     underrun,
    output logic [CYC_W-1:0]         mismatch_cycle
);

    logic [CYC_W-1:0] cyc;
    gpm_flags_t       flags;

    gpm_sig_reduce #(
        .NUM_SIG (NUM_SIG),
        .SIG_W   (SIG_W)
    ) u_reduce (
        .sig_bus     (sig_bus),
        .sig_mask    (sig_mask),
        .comp_parity (comp_parity)
    );

    gpm_period_timer #(
        .PER_W (PER_W),
        .CYC_W (CYC_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period),
        .strobe (check_strobe),
        .cyc    (cyc)
    );

    gpm_verdict #(
        .CYC_W (CYC_W)
    ) u_verdict (
        .clk            (clk),
        .rst_n          (rst_n),
        .strobe         (check_strobe),
        .comp_parity    (comp_parity),
        .gold_bit       (gold_bit),
        .gold_valid     (gold_valid),
        .cyc            (cyc),
        .gold_ack       (gold_ack),
        .flags          (flags),
        .mismatch_cycle (mismatch_cycle)
    );

    assign halt     = flags.halt;
    assign underrun = flags.underrun;

endmodule

// File: tb/gold_parity_monitor_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module gold_parity_monitor_bench;

    localparam int unsigned NS = 4;
    localparam int unsigned SW = 16;
    localparam int unsigned BW = NS*SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [BW-1:0] sig_bus = '0;
    logic [BW-1:0] sig_mask = '0;
    logic [15:0]   period = 16'd4;
    logic          gold_bit = 1'b0;
    logic          gold_valid = 1'b0;
    logic          gold_ack, check_strobe, comp_parity, halt, underrun;
    logic [31:0]   mismatch_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gold_parity_monitor u_gold_parity_monitor (
        .clk(clk), .rst_n(rst_n), .sig_bus(sig_bus), .sig_mask(sig_mask),
        .period(period), .gold_bit(gold_bit), .gold_valid(gold_valid),
        .gold_ack(gold_ack), .check_strobe(check_strobe), .comp_parity(comp_parity),
        .halt(halt), .underrun(underrun), .mismatch_cycle(mismatch_cycle)
    );

    function automatic logic ref_par(input logic [BW-1:0] s, input logic [BW-1:0] m);
        logic r;
        r = 1'b0;
        for (int i = 0; i < BW; i++) r ^= (s[i] & m[i]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reset with a chosen period; returns at the start of cycle index 0
    task automatic do_reset(input logic [15:0] p);
        rst_n = 1'b0; gold_valid = 1'b0; gold_bit = 1'b0; period = p;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(16'd4);
        #1;
        chk(halt == 1'b0, "R1", "halt", halt, 0);
        chk(underrun == 1'b0, "R1", "underrun", underrun, 0);
        chk(mismatch_cycle == 32'd0, "R1", "mismatch_cycle", mismatch_cycle, 0);
    endtask

    task automatic t_parity;
        logic [BW-1:0] s;
        logic          p0;
        do_reset(16'd1000);
        s = 64'hA5C3_0F1E_7B29_D406;
        sig_bus = s; sig_mask = '1; #1;
        chk(comp_parity == ref_par(s, '1), "R3", "full mask", comp_parity, ref_par(s, '1));
        sig_mask = 64'h0000_FFFF_0000_0000; #1;
        chk(comp_parity == ref_par(s, sig_mask), "R3", "one signature", comp_parity, ref_par(s, sig_mask));
        sig_bus = '1; sig_mask = '0; #1;
        chk(comp_parity == 1'b0, "R2", "empty mask", comp_parity, 0);
        sig_bus = s; sig_mask = 64'h00F0_0000_0F00_0001; #1;
        p0 = comp_parity;
        chk(p0 == ref_par(s, sig_mask), "R2", "sparse mask", p0, ref_par(s, sig_mask));
        sig_bus = s ^ 64'h0F0F_0000_0000_0000; #1;
        chk(comp_parity == p0, "R2", "unselected flips", comp_parity, p0);
        sig_bus = s ^ 64'h0000_0000_0300_0000; #1;
        chk(comp_parity == p0, "R11", "even selected flips", comp_parity, p0);
        sig_bus = s ^ 64'h0000_0000_0100_0000; #1;
        chk(comp_parity == ~p0, "R3", "single selected flip", comp_parity, ~p0);
    endtask

    task automatic t_period;
        do_reset(16'd5);
        sig_bus = '0; sig_mask = '1; gold_valid = 1'b1; gold_bit = 1'b0;
        for (int n = 0; n < 15; n++) begin
            #1;
            chk(check_strobe == (n % 5 == 4), "R4", $sformatf("strobe n=%0d", n), check_strobe, (n % 5 == 4));
            chk(gold_ack == (n % 5 == 4), "R5", $sformatf("ack n=%0d", n), gold_ack, (n % 5 == 4));
            @(negedge clk);
        end
        chk(halt == 1'b0, "R6", "no halt on matches", halt, 0);
    endtask

    task automatic t_mismatch;
        logic [BW-1:0] s;
        logic          p;
        do_reset(16'd4);
        s = 64'h1234_5678_9ABC_DEF1;
        sig_bus = s; sig_mask = '1; p = ref_par(s, '1);
        for (int n = 0; n < 17; n++) begin
            gold_valid = 1'b1;
            gold_bit   = (n == 11 || n == 15) ? ~p : p;
            #1;
            if (n == 15) chk(gold_ack == 1'b0, "R5", "no ack after halt", gold_ack, 0);
            @(negedge clk);
            if (n < 11) chk(halt == 1'b0, "R6", $sformatf("halt early n=%0d", n), halt, 0);
            if (n == 11) begin
                chk(halt == 1'b1, "R6", "halt after mismatch", halt, 1);
                chk(mismatch_cycle == 32'd11, "R7", "captured cycle", mismatch_cycle, 11);
            end
        end
        chk(halt == 1'b1, "R6", "halt held", halt, 1);
        chk(mismatch_cycle == 32'd11, "R7", "capture held", mismatch_cycle, 11);
    endtask

    task automatic t_underrun;
        logic p;
        do_reset(16'd3);
        sig_bus = 64'h0000_0000_0000_0007; sig_mask = '1; p = 1'b1;
        for (int n = 0; n < 6; n++) begin
            gold_valid = (n != 2);
            gold_bit   = (n == 2) ? ~p : p;
            #1;
            if (n == 2) chk(gold_ack == 1'b0, "R5", "no ack without data", gold_ack, 0);
            @(negedge clk);
            if (n == 2) chk(underrun == 1'b1, "R8", "underrun set", underrun, 1);
        end
        chk(underrun == 1'b1, "R8", "underrun sticky", underrun, 1);
        chk(halt == 1'b0, "R8", "no compare on underrun", halt, 0);
    endtask

    task automatic t_shrink;
        do_reset(16'd10);
        sig_bus = '0; sig_mask = '1; gold_valid = 1'b1; gold_bit = 1'b0;
        for (int n = 0; n < 11; n++) begin
            if (n == 7) period = 16'd3;
            #1;
            chk(check_strobe == (n == 7 || n == 10), "R10", $sformatf("strobe n=%0d", n),
                check_strobe, (n == 7 || n == 10));
            @(negedge clk);
        end
    endtask

    task automatic t_small_period;
        do_reset(16'd0);
        sig_bus = '0; sig_mask = '1; gold_valid = 1'b1; gold_bit = 1'b0;
        for (int n = 0; n < 6; n++) begin
            if (n == 3) period = 16'd1;
            #1;
            chk(check_strobe == 1'b1, "R9", $sformatf("strobe n=%0d", n), check_strobe, 1);
            @(negedge clk);
        end
    endtask

    initial begin
        t_reset();
        t_parity();
        t_period();
        t_mismatch();
        t_underrun();
        t_shrink();
        t_small_period();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule